// File: doc/BRIEF.md
# Fetch-to-decode instruction morpher

This block sits on the instruction wire between a fetch unit and a decoder. When morphing is enabled, it can swap a fetched 32-bit instruction word for a mutated word. Every swap is stored in a small map. The map key is the original word together with the address it came from, so any later fetch of that pair gets exactly the same replacement. A reference model can query the map through a separate lookup port and apply the same change. As a result, the core and the model always run identical altered code.

The PC, the valid strobe and the ready back-pressure pass straight through, and the fetch offset never changes. Only the instruction word is rewritten. The back end therefore needs no change. New replacements come from a 32-bit Galois LFSR. Compressed (16-bit) encodings are never touched, and the length class of a 32-bit word is kept.

Top module: `insn_morpher`

## Requirements
- R1: `d_valid` equals `f_valid`, `d_pc` equals `f_pc` and `f_ready` equals `d_ready` in the same cycle. The block adds no latency.
- R2: When morphing is disabled and the key (`f_pc`, `f_insn`) misses the map, `d_insn` equals `f_insn` and no entry is created. A later query of that key misses.
- R3: When morphing is enabled, a 32-bit word (bits [1:0] = 2'b11) that misses the map is sent on as {L[31:2], 2'b11}, where L is the current LFSR state. The entry is written when the transfer completes (`f_valid` and `d_ready`). L then takes one Galois step: L = (L >> 1) ^ (L[0] ? 32'h80200003 : 0), starting from the seed 32'h1D872B41.
- R4: Once a key is in the map, every later fetch of that key sends the stored value, whether morphing is enabled or not.
- R5: A morphed word always has bits [1:0] = 2'b11.
- R6: A word with bits [1:0] other than 2'b11 passes through unchanged and is never stored.
- R7: While a fetch is held (`f_valid` high, `d_ready` low), nothing is stored and the LFSR does not move, so `d_insn` stays stable until the transfer completes.
- R8: The lookup port is combinational. With `q_valid` high, `q_hit` shows whether (`q_pc`, `q_insn`) is in the map and `q_morph` gives the stored value.
- R9: A fetch-side insertion takes priority over a query in the same cycle. A query of the key being inserted reports a hit with the new value. A query of the key in the slot being overwritten reports a miss.
- R10: The map holds 32 entries, replaced round-robin from slot 0. An evicted key gets a fresh morph on its next enabled fetch, and that morph is stored.
- R11: After reset the map is empty, the LFSR holds the seed and the replacement pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| morph_en | input | 1 | Allows new morphs to be created on a map miss |
| f_valid | input | 1 | Fetch word valid |
| f_pc | input | 32 | Fetch address |
| f_insn | input | 32 | Fetched instruction word |
| f_ready | output | 1 | Back-pressure to fetch, copied from decode |
| d_valid | output | 1 | Decode word valid |
| d_pc | output | 32 | Address sent to decode |
| d_insn | output | 32 | Instruction word sent to decode, possibly morphed |
| d_ready | input | 1 | Decode accepts the word |
| q_valid | input | 1 | Lookup request |
| q_pc | input | 32 | Lookup address |
| q_insn | input | 32 | Lookup original word |
| q_hit | output | 1 | Lookup found an entry |
| q_morph | output | 32 | Stored morphed word, zero on a miss |

## Verification
The bench keeps its own map, pointer and LFSR model and goes after several corner cases:
- **Held fetch.** A design that stored the word on a held fetch would burn LFSR values and leave a stray entry, so later morphs would fail to match.
- **Full wrap.** Filling all 32 slots and then inserting two more keys shows whether replacement begins at slot 0 and whether an evicted key gets a new value rather than its stale one.
- **Same-cycle query.** Queries issued in the same cycle as an insertion catch a design that reports the victim slot as still present or misses the key being inserted.
- **Hit with morphing off.** Refetching every key with morphing disabled catches a design that lets the enable override existing entries.
- **Compressed word.** A compressed word catches a design that rewrites or stores 16-bit encodings.

// File: rtl/insn_morpher.sv
module insn_morpher #(
  parameter int          PC_W    = 32,
  parameter int          ENTRIES = 32,
  parameter logic [31:0] SEED    = 32'h1D872B41,
  parameter logic [31:0] TAPS    = 32'h80200003,
  localparam int         IDX_W   = $clog2(ENTRIES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            morph_en,
  input  logic            f_valid,
  input  logic [PC_W-1:0] f_pc,
  input  logic [31:0]     f_insn,
  output logic            f_ready,
  output logic            d_valid,
  output logic [PC_W-1:0] d_pc,
  output logic [31:0]     d_insn,
  input  logic            d_ready,
  input  logic            q_valid,
  input  logic [PC_W-1:0] q_pc,
  input  logic [31:0]     q_insn,
  output logic            q_hit,
  output logic [31:0]     q_morph
);

  logic [ENTRIES-1:0] vld;
  logic [PC_W-1:0]    pc_q  [ENTRIES];
  logic [31:0]        key_q [ENTRIES];
  logic [31:0]        val_q [ENTRIES];
  logic [IDX_W-1:0]   ptr;
  logic [31:0]        lfsr;

  logic [ENTRIES-1:0] f_match, q_match, victim, q_live;
  logic [31:0]        f_val, q_val, fresh;
  logic               f_hit, wide, ins, q_bypass;

  assign f_ready = d_ready;
  assign d_valid = f_valid;
  assign d_pc    = f_pc;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign f_match[g] = vld[g] && pc_q[g] == f_pc && key_q[g] == f_insn;
      assign q_match[g] = vld[g] && pc_q[g] == q_pc && key_q[g] == q_insn;
      assign victim[g]  = ins && ptr == IDX_W'(g);
    end
  endgenerate

  always_comb begin
    f_val = '0;
    q_val = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (f_match[i]) f_val |= val_q[i];
      if (q_live[i])  q_val |= val_q[i];
    end
  end

  assign wide  = f_insn[1:0] == 2'b11;
  assign f_hit = |f_match;
  assign fresh = {lfsr[31:2], 2'b11};
  assign ins   = f_valid && d_ready && morph_en && wide && !f_hit;

  assign d_insn = f_hit ? f_val : (morph_en && wide) ? fresh : f_insn;

  assign q_live   = q_match & ~victim;
  assign q_bypass = ins && q_pc == f_pc && q_insn == f_insn;
  assign q_hit    = q_valid && (q_bypass || |q_live);
  assign q_morph  = !q_valid ? '0 : q_bypass ? fresh : q_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      ptr  <= '0;
      lfsr <= SEED;
    end else if (ins) begin
      vld[ptr] <= 1'b1;
      ptr      <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
      lfsr     <= {1'b0, lfsr[31:1]} ^ (lfsr[0] ? TAPS : 32'h0);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (victim[i]) begin
        pc_q[i]  <= f_pc;
        key_q[i] <= f_insn;
        val_q[i] <= fresh;
      end
    end
  end

endmodule

module insn_morpher_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            morph_en,
  input logic            f_valid,
  input logic [PC_W-1:0] f_pc,
  input logic [31:0]     f_insn,
  input logic [31:0]     d_insn,
  input logic            d_ready,
  input logic            q_valid,
  input logic [PC_W-1:0] q_pc,
  input logic [31:0]     q_insn,
  input logic            q_hit,
  input logic [31:0]     q_morph
);

  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  assert_len_class_R5: assert property (@(posedge clk) disable iff (!rst_n)
    f_valid && f_insn[1:0] == 2'b11 |-> d_insn[1:0] == 2'b11);

  assert_short_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    f_valid && f_insn[1:0] != 2'b11 |-> d_insn == f_insn);

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed && f_valid && $past(f_valid && !d_ready) && $stable(f_pc) &&
    $stable(f_insn) && $stable(morph_en) |-> $stable(d_insn));

  assert_repeat_same_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && f_valid && $past(f_valid && d_ready) && $stable(f_pc) &&
    $stable(f_insn) && $past(d_insn != f_insn) |-> $stable(d_insn));

  assert_query_agrees_R8: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && f_valid && d_ready && q_pc == f_pc && q_insn == f_insn &&
    d_insn != f_insn |-> q_hit && q_morph == d_insn);

endmodule

bind insn_morpher insn_morpher_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .morph_en(morph_en), .f_valid(f_valid),
  .f_pc(f_pc), .f_insn(f_insn), .d_insn(d_insn), .d_ready(d_ready),
  .q_valid(q_valid), .q_pc(q_pc), .q_insn(q_insn), .q_hit(q_hit),
  .q_morph(q_morph)
);

// File: tb/tb_insn_morpher.sv
module tb_insn_morpher;
  logic        clk = 0, rst_n = 0, morph_en = 0;
  logic        f_valid = 0, d_ready = 0, q_valid = 0;
  logic [31:0] f_pc = 0, f_insn = 0, q_pc = 0, q_insn = 0;
  logic        f_ready, d_valid, q_hit;
  logic [31:0] d_pc, d_insn, q_morph;

  always #2 clk = ~clk;

  insn_morpher dut (
    .clk(clk), .rst_n(rst_n), .morph_en(morph_en), .f_valid(f_valid),
    .f_pc(f_pc), .f_insn(f_insn), .f_ready(f_ready), .d_valid(d_valid),
    .d_pc(d_pc), .d_insn(d_insn), .d_ready(d_ready), .q_valid(q_valid),
    .q_pc(q_pc), .q_insn(q_insn), .q_hit(q_hit), .q_morph(q_morph)
  );

  int          n_chk = 0, n_fail = 0;
  logic [31:0] m_pc [32], m_in [32], m_val [32];
  bit          m_v [32];
  int          m_ptr = 0;
  logic [31:0] m_lfsr = 32'h1D872B41;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] pc, input logic [31:0] insn, input bit en, input bit rdy,
                      input bit qv, input logic [31:0] qpc, input logic [31:0] qin,
                      input string tag, input string qtag);
    bit hit, ins, qh;
    logic [31:0] hv, fresh, exp, qm;
    @(negedge clk);
    f_valid = 1; f_pc = pc; f_insn = insn; morph_en = en; d_ready = rdy;
    q_valid = qv; q_pc = qpc; q_insn = qin;
    #1;
    hit = 0; hv = 0;
    for (int k = 0; k < 32; k++)
      if (m_v[k] && m_pc[k] == pc && m_in[k] == insn) begin hit = 1; hv = m_val[k]; end
    fresh = {m_lfsr[31:2], 2'b11};
    exp = hit ? hv : (en && insn[1:0] == 2'b11) ? fresh : insn;
    ins = rdy && en && insn[1:0] == 2'b11 && !hit;
    qh = 0; qm = 0;
    if (qv) begin
      if (ins && qpc == pc && qin == insn) begin qh = 1; qm = fresh; end
      else
        for (int k = 0; k < 32; k++)
          if (m_v[k] && m_pc[k] == qpc && m_in[k] == qin && !(ins && k == m_ptr)) begin
            qh = 1; qm = m_val[k];
          end
    end
    chk(d_insn == exp, tag, {32'h0, d_insn}, {32'h0, exp});
    chk(d_pc == pc && d_valid && f_ready == rdy, "R1 passthrough",
        {d_pc, 31'h0, f_ready}, {pc, 31'h0, rdy});
    if (insn[1:0] == 2'b11 && exp != insn)
      chk(d_insn[1:0] == 2'b11, "R5 length class", {62'h0, d_insn[1:0]}, 64'h3);
    if (qv) begin
      chk(q_hit == qh, qtag, {63'h0, q_hit}, {63'h0, qh});
      if (qh) chk(q_morph == qm, qtag, {32'h0, q_morph}, {32'h0, qm});
    end
    @(posedge clk);
    if (ins) begin
      m_v[m_ptr] = 1; m_pc[m_ptr] = pc; m_in[m_ptr] = insn; m_val[m_ptr] = fresh;
      m_ptr = (m_ptr + 1) % 32;
      m_lfsr = (m_lfsr >> 1) ^ (m_lfsr[0] ? 32'h80200003 : 32'h0);
    end
  endtask

  function automatic logic [31:0] key_insn(input int i);
    return {i[7:0], 8'h5A, i[7:0], 8'h13} | 32'h3;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all requirements actual=expired expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 32; k++) m_v[k] = 0;
    q_valid = 1; q_pc = 32'h40; q_insn = 32'h13;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(q_hit == 0, "R11 empty after reset", {63'h0, q_hit}, 64'h0);
    chk(d_valid == 0, "R1 valid passthrough", {63'h0, d_valid}, 64'h0);
    rst_n = 1;

    // R2: disabled miss passes through and stores nothing
    step(32'h100, 32'h00000013, 0, 1, 0, 0, 0, "R2 disabled passthrough", "");
    step(32'h104, 32'h00000093, 0, 1, 1, 32'h100, 32'h00000013, "R2 disabled passthrough", "R2 no entry");

    // R6: compressed word untouched
    step(32'h108, 32'h00004501, 1, 1, 0, 0, 0, "R6 compressed passthrough", "");
    step(32'h10C, 32'h00004505, 0, 1, 1, 32'h108, 32'h00004501, "R6 compressed passthrough", "R6 not stored");

    // R7: held fetch creates nothing until accepted
    for (int s = 0; s < 3; s++)
      step(32'h200, 32'h00A00093, 1, 0, 1, 32'h200, 32'h00A00093, "R7 held output", "R7 nothing stored");
    step(32'h200, 32'h00A00093, 1, 1, 1, 32'h200, 32'h00A00093, "R7 accepted morph", "R9 bypass on insert");

    // R3: fill the remaining slots
    for (int i = 1; i < 32; i++)
      step(32'h1000 + 4 * i, key_insn(i), 1, 1, 0, 0, 0, "R3 fresh morph", "");

    // R4 and R8: replay every key with morphing off, querying it at the same time
    step(32'h200, 32'h00A00093, 0, 1, 1, 32'h200, 32'h00A00093, "R4 stored morph", "R8 lookup");
    for (int i = 1; i < 32; i++)
      step(32'h1000 + 4 * i, key_insn(i), 0, 1, 1, 32'h1000 + 4 * i, key_insn(i), "R4 stored morph", "R8 lookup");

    // R10 and R9: same word at a new address evicts slot 0 while the victim is queried
    step(32'h1100, key_insn(1), 1, 1, 1, 32'h200, 32'h00A00093, "R10 new key same word", "R9 victim misses");
    step(32'h300, 32'h00B00113, 0, 1, 1, 32'h200, 32'h00A00093, "R2 disabled miss", "R10 evicted key gone");
    step(32'h200, 32'h00A00093, 1, 1, 1, 32'h200, 32'h00A00093, "R10 fresh after eviction", "R9 bypass on insert");
    step(32'h200, 32'h00A00093, 0, 1, 1, 32'h1004, key_insn(1), "R4 new morph held", "R10 slot 1 evicted");
    step(32'h1008, key_insn(2), 1, 1, 1, 32'h1100, key_insn(1), "R4 hit when enabled", "R8 lookup");

    @(negedge clk);
    f_valid = 0; q_valid = 0;
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule